// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins, always a multiple of 32. Software reaches it over a simple 32-bit register bus. Each pin has an input, an output and an output-enable. Each pin can also be set to flag rising or falling transitions. All pending flags are merged into one interrupt line.

The register space is grouped by register kind, not by pin bank. All the words of one kind sit next to each other, and the next kind follows. The address stride between kinds therefore grows with the pin count. Software never writes the output latch directly. It writes ones to a set word to drive pins high, and ones to a clear word to drive them low. Edge flags are sticky. They stay set until software writes a one to them, and the interrupt is asserted while any flag is set. An interrupt handler walks the status words one at a time and skips any word that reads zero.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: With W = PIN_COUNT/32 words per kind, word w of kind k is at byte address (k*W + w)*4, and address bits [1:0] are ignored. Pin p is bit p%32 of word p/32. The kind indices are: level 0, direction 1, set 2, clear 3, rising enable 4, falling enable 5, edge status 6. Read data appears on `bus_rdata` at the clock edge that samples the read request and is held until the next read.
- R2: The level kind is read-only. It returns `pin_in` after a two-flop synchroniser, so a pin change becomes readable two clock edges after it is sampled. Writes to it are ignored.
- R3: The direction kind reads back exactly what was written. A direction bit of 1 makes the pin an output: `pin_oe` carries the direction bits.
- R4: Writing 1 to a bit of the set kind drives that pin's output latch, seen on `pin_out`, high. Bits written as 0 leave the latch unchanged.
- R5: Writing 1 to a bit of the clear kind drives that pin's output latch low. Bits written as 0 leave the latch unchanged.
- R6: The set and clear kinds always read back as zero.
- R7: When a pin's rising-enable bit is 1, a 0-to-1 change of its synchronised level sets its edge-status bit. The bit is set at the third clock edge after the new input value is first sampled.
- R8: When a pin's falling-enable bit is 1, a 1-to-0 change of its synchronised level sets its edge-status bit. With only the other enable set, that transition sets nothing. With both enables set, both transitions set the bit.
- R9: Edge-status bits are sticky and are cleared by writing 1 to them. If a new enabled edge arrives at the same clock edge as the clearing write, the bit stays set.
- R10: `irq` is a register holding the OR of all edge-status bits. It follows the status one clock edge later.
- R11: Addresses at or beyond 7*W words read as zero. Writes to them change no state.
- R12: After reset, every pin is an input (`pin_oe` = 0), the output latch is 0, both edge enables are 0, all status bits are 0, `irq` is 0 and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | PIN_COUNT | Asynchronous pin input levels |
| pin_out | output | PIN_COUNT | Output latch values |
| pin_oe | output | PIN_COUNT | Output enables (direction bits) |
| irq | output | 1 | Combined edge interrupt |

## Verification
Two functions can fall in the same clock edge: the write-one clear of an edge-status bit, and the setting of that same bit by a new enabled edge. The bench provokes this by changing a pin whose edge was already flagged. It then issues the clearing write so that the write is captured at exactly the third edge after the pin change, which is the edge at which detection fires. It judges the result by reading the status word back and expecting the bit still set. A second, plain clear afterwards must drop the bit.

// File: rtl/gpio_bank_pkg.sv
// Package: shared types and constants for the banked GPIO controller.
// Assumes: register kinds are laid out kind-major, indices fixed below.
package gpio_bank_pkg;

    localparam int WORD_BITS = 32;
    localparam int NUM_KINDS = 7;

    // Register kind index; the numeric order fixes the address map.
    typedef enum logic [2:0] {
        KIND_LEVEL   = 3'd0,
        KIND_DIR     = 3'd1,
        KIND_SET     = 3'd2,
        KIND_CLR     = 3'd3,
        KIND_RISE_EN = 3'd4,
        KIND_FALL_EN = 3'd5,
        KIND_STATUS  = 3'd6
    } gpio_kind_e;

endpackage

// File: rtl/gpio_addr_decode.sv
// Module: gpio_addr_decode
// Splits a byte address into a register kind and a one-hot word select.
// Assumes: NREG words per kind, kinds stored one after another; bits [1:0]
// of the address are ignored. Addresses past the last kind give hit = 0.
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NREG   = 2,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              hit,
    output gpio_kind_e        kind,
    output logic [NREG-1:0]   word_sel
);

    localparam int          WIDX_W  = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [31:0] NREG_U  = 32'(NREG);
    localparam logic [31:0] SLOTS_U = 32'(NUM_KINDS * NREG);

    logic [31:0] slot_ext;
    logic [31:0] kind_ext;
    logic [31:0] word_ext;
    logic        unused_addr_bits;

    // Word slot index, then kind = slot / NREG and word = slot % NREG.
    always_comb begin
        slot_ext = 32'(bus_addr[ADDR_W-1:2]);
        kind_ext = slot_ext / NREG_U;
        word_ext = slot_ext % NREG_U;
        hit      = (slot_ext < SLOTS_U);
        kind     = hit ? gpio_kind_e'(kind_ext[2:0]) : KIND_LEVEL;
        word_sel = hit ? (NREG'(1) << word_ext[WIDX_W-1:0]) : '0;
    end

    assign unused_addr_bits = ^{bus_addr[1:0], kind_ext[31:3], word_ext[31:WIDX_W]};

    // R1: a decoded access selects exactly one word of its kind.
    always_comb begin
        if (hit) begin
            assert_word_onehot_R1: assert ($countones(word_sel) == 1);
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Two-flop synchroniser on every pin, plus a delayed copy for edge detection.
// Assumes: pin_in is asynchronous to clk; all flops reset to zero.
module gpio_in_sync #(
    parameter int PINS = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] level,
    output logic [PINS-1:0] rise,
    output logic [PINS-1:0] fall
);

    logic [PINS-1:0] meta_q;
    logic [PINS-1:0] sync_q;
    logic [PINS-1:0] prev_q;

    // Synchroniser chain and one-cycle history of the synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge pulses: the synchronised value differs from its delayed copy.
    always_comb begin
        level = sync_q;
        rise  = sync_q & ~prev_q;
        fall  = ~sync_q & prev_q;
    end

endmodule

// File: rtl/gpio_pin_ctrl.sv
// Module: gpio_pin_ctrl
// Holds direction, output latch and the two edge-enable registers, and
// turns a decoded write into per-pin masks. The output latch changes only
// through the write-one set and clear kinds.
// Assumes: wr_en is already qualified by an in-range address.
module gpio_pin_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NREG = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  gpio_kind_e                kind,
    input  logic [NREG-1:0]           word_sel,
    input  logic [WORD_BITS-1:0]      wdata,
    output logic [NREG*WORD_BITS-1:0] dir_q,
    output logic [NREG*WORD_BITS-1:0] out_q,
    output logic [NREG*WORD_BITS-1:0] rise_en_q,
    output logic [NREG*WORD_BITS-1:0] fall_en_q,
    output logic [NREG*WORD_BITS-1:0] status_clr
);

    localparam int PINS = NREG * WORD_BITS;

    logic [PINS-1:0] wide_data;
    logic [PINS-1:0] wide_sel;

    // Place the write word on the selected bank; other banks see zeros.
    for (genvar w = 0; w < NREG; w++) begin : g_bank
        assign wide_data[w*WORD_BITS +: WORD_BITS] = word_sel[w] ? wdata : '0;
        assign wide_sel[w*WORD_BITS +: WORD_BITS]  = {WORD_BITS{word_sel[w]}};
    end

    // Write-one-to-clear mask handed to the edge status block.
    assign status_clr = (wr_en && kind == KIND_STATUS) ? wide_data : '0;

    // Register updates: plain writes for direction and enables, W1S/W1C for latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= '0;
            out_q     <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else if (wr_en) begin
            case (kind)
                KIND_DIR:     dir_q     <= (dir_q & ~wide_sel) | wide_data;
                KIND_SET:     out_q     <= out_q | wide_data;
                KIND_CLR:     out_q     <= out_q & ~wide_data;
                KIND_RISE_EN: rise_en_q <= (rise_en_q & ~wide_sel) | wide_data;
                KIND_FALL_EN: fall_en_q <= (fall_en_q & ~wide_sel) | wide_data;
                default:      ;
            endcase
        end
    end

    // R4: written ones appear high on the latch afterwards.
    assert_set_drives_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == KIND_SET) |=> ((out_q & $past(wide_data)) == $past(wide_data)));

    // R4/R5: zero bits of a set or clear write leave the latch alone.
    assert_zero_bits_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (kind == KIND_SET || kind == KIND_CLR)) |=>
        ((out_q & ~$past(wide_data)) == ($past(out_q) & ~$past(wide_data))));

    // R5: written ones appear low on the latch afterwards.
    assert_clear_drives_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == KIND_CLR) |=> ((out_q & $past(wide_data)) == '0));

    // R11: without an in-range write, no control register moves.
    assert_no_write_no_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(dir_q) && $stable(out_q) && $stable(rise_en_q) && $stable(fall_en_q)));

endmodule

// File: rtl/gpio_edge_status.sv
// Module: gpio_edge_status
// Sticky per-pin edge flags. Enabled edges set a flag and a write-one clears
// it; a new edge at the same clock edge as its clear keeps the flag set.
// Assumes: rise/fall come from synchronised levels and are one-cycle pulses.
module gpio_edge_status #(
    parameter int PINS = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] rise,
    input  logic [PINS-1:0] fall,
    input  logic [PINS-1:0] rise_en,
    input  logic [PINS-1:0] fall_en,
    input  logic [PINS-1:0] clr_mask,
    output logic [PINS-1:0] status_q
);

    logic [PINS-1:0] set_vec;

    // Enabled edges that request a flag this cycle.
    assign set_vec = (rise & rise_en) | (fall & fall_en);

    // Clear first, then set, so the edge wins a same-cycle conflict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | set_vec;
        end
    end

    // R9: every requested flag is set on the next edge, even under a clear.
    assert_edge_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    // R9: cleared flags with no new edge are low on the next edge.
    assert_clear_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_mask) |=> ((status_q & $past(clr_mask) & ~$past(set_vec)) == '0));

    // R7: a flag only appears when an enabled edge asked for it.
    assert_no_spurious_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0));

endmodule

// File: rtl/gpio_bank_ctrl.sv
// Module: gpio_bank_ctrl (top)
// Banked GPIO controller: kind-major register map on a 32-bit bus, write-one
// set/clear output latch, synchronised inputs, sticky edge flags and a
// registered combined interrupt.
// Assumes: PIN_COUNT is a multiple of 32 and 7*PIN_COUNT/32 words fit in
// ADDR_W byte-address bits. Reads complete in one cycle with registered data.
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int PIN_COUNT = 64,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);

    localparam int NREG = PIN_COUNT / WORD_BITS;

    logic                 hit;
    gpio_kind_e           kind;
    logic [NREG-1:0]      word_sel;
    logic                 wr_en;
    logic                 rd_en;
    logic [PIN_COUNT-1:0] level;
    logic [PIN_COUNT-1:0] rise;
    logic [PIN_COUNT-1:0] fall;
    logic [PIN_COUNT-1:0] dir_q;
    logic [PIN_COUNT-1:0] out_q;
    logic [PIN_COUNT-1:0] rise_en_q;
    logic [PIN_COUNT-1:0] fall_en_q;
    logic [PIN_COUNT-1:0] status_clr;
    logic [PIN_COUNT-1:0] status_q;
    logic [PIN_COUNT-1:0] rd_src;
    logic [31:0]          rd_word;
    logic [31:0]          rdata_q;
    logic                 irq_q;

    // Qualified bus strobes.
    assign wr_en = bus_sel && bus_we && hit;
    assign rd_en = bus_sel && !bus_we;

    gpio_addr_decode #(.NREG(NREG), .ADDR_W(ADDR_W)) u_decode (
        .bus_addr (bus_addr),
        .hit      (hit),
        .kind     (kind),
        .word_sel (word_sel)
    );

    gpio_in_sync #(.PINS(PIN_COUNT)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .level  (level),
        .rise   (rise),
        .fall   (fall)
    );

    gpio_pin_ctrl #(.NREG(NREG)) u_pinctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .kind       (kind),
        .word_sel   (word_sel),
        .wdata      (bus_wdata),
        .dir_q      (dir_q),
        .out_q      (out_q),
        .rise_en_q  (rise_en_q),
        .fall_en_q  (fall_en_q),
        .status_clr (status_clr)
    );

    gpio_edge_status #(.PINS(PIN_COUNT)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .fall     (fall),
        .rise_en  (rise_en_q),
        .fall_en  (fall_en_q),
        .clr_mask (status_clr),
        .status_q (status_q)
    );

    // Pick the register vector of the addressed kind; set/clear read zero.
    always_comb begin
        case (kind)
            KIND_LEVEL:   rd_src = level;
            KIND_DIR:     rd_src = dir_q;
            KIND_RISE_EN: rd_src = rise_en_q;
            KIND_FALL_EN: rd_src = fall_en_q;
            KIND_STATUS:  rd_src = status_q;
            default:      rd_src = '0;
        endcase
    end

    // Pick the addressed word; an out-of-range address selects none.
    always_comb begin
        rd_word = '0;
        for (int w = 0; w < NREG; w++) begin
            if (word_sel[w]) begin
                rd_word = rd_word | rd_src[w*WORD_BITS +: WORD_BITS];
            end
        end
    end

    // Read data register and registered interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (rd_en) begin
                rdata_q <= rd_word;
            end
            irq_q <= |status_q;
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = irq_q;
    assign pin_out   = out_q;
    assign pin_oe    = dir_q;

    // R10: any pending flag raises the interrupt on the next edge.
    assert_irq_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_q) |=> irq);

    // R10: no pending flag drops the interrupt on the next edge.
    assert_irq_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(|status_q) |=> !irq);

    // R6: set and clear kinds read as zero.
    assert_setclr_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit && (kind == KIND_SET || kind == KIND_CLR)) |=> (bus_rdata == '0));

    // R11: reads past the map return zero.
    assert_oob_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> (bus_rdata == '0));

    // R1: read data holds between reads.
    assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(bus_rdata));

endmodule

// File: tb/gpio_bank_ctrl_bench.sv
// Bench: scoreboard of expected read words; a driver task pushes each
// expectation as it issues a read, a monitor pops and compares the result.
module gpio_bank_ctrl_bench;

    localparam int PINS   = 64;
    localparam int NREG   = PINS / 32;
    localparam int ADDR_W = 8;

    localparam int K_LEVEL = 0;
    localparam int K_DIR   = 1;
    localparam int K_SET   = 2;
    localparam int K_CLR   = 3;
    localparam int K_RISE  = 4;
    localparam int K_FALL  = 5;
    localparam int K_STAT  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [PINS-1:0]   pins = '0;
    logic [PINS-1:0]   pin_out;
    logic [PINS-1:0]   pin_oe;
    logic              irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    string       exp_req[$];
    logic [31:0] exp_val[$];
    logic        pend = 1'b0;

    always #2 clk = ~clk;

    gpio_bank_ctrl #(.PIN_COUNT(PINS), .ADDR_W(ADDR_W)) u_gpio_bank_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pins),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    function automatic logic [ADDR_W-1:0] addr_of(int k, int w);
        return ADDR_W'((k * NREG + w) * 4);
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [ADDR_W-1:0] a, logic [31:0] d);
        bus_sel   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0;
        bus_we  = 1'b0;
    endtask

    task automatic bus_read(logic [ADDR_W-1:0] a, logic [31:0] exp, string req);
        exp_req.push_back(req);
        exp_val.push_back(exp);
        bus_sel  = 1'b1;
        bus_we   = 1'b0;
        bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Monitor: note a read request at the edge, compare its data half a cycle later.
    always @(posedge clk) pend <= bus_sel && !bus_we && rst_n;

    always @(negedge clk) begin
        if (pend) begin
            checks++;
            if (exp_val.size() == 0) begin
                failures++;
                $display("FAIL scoreboard: actual=%h expected=none", bus_rdata);
            end else begin
                string       r;
                logic [31:0] e;
                r = exp_req.pop_front();
                e = exp_val.pop_front();
                if (bus_rdata !== e) begin
                    failures++;
                    $display("FAIL %s: actual=%h expected=%h", r, bus_rdata, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R12: reset state
        chk("R12 pin_out", pin_out, '0);
        chk("R12 pin_oe", pin_oe, '0);
        chk("R12 irq", 64'(irq), 64'd0);
        chk("R12 rdata", 64'(bus_rdata), 64'd0);
        bus_read(addr_of(K_DIR, 0), 32'h0, "R12 dir word0");
        bus_read(addr_of(K_RISE, 1), 32'h0, "R12 rise enable word1");
        bus_read(addr_of(K_STAT, 0), 32'h0, "R12 status word0");

        // R3: direction read-back and pin_oe
        bus_write(addr_of(K_DIR, 1), 32'hA5A5_0F0F);
        bus_read(addr_of(K_DIR, 1), 32'hA5A5_0F0F, "R3 dir word1 readback");
        bus_read(addr_of(K_DIR, 0), 32'h0, "R3 dir word0 untouched");
        chk("R3 pin_oe", pin_oe, 64'hA5A5_0F0F_0000_0000);

        // R4/R5/R6: write-one set and clear
        bus_write(addr_of(K_SET, 0), 32'h0000_00F0);
        chk("R4 set word0", pin_out, 64'h0000_0000_0000_00F0);
        bus_write(addr_of(K_SET, 0), 32'h0000_000F);
        chk("R4 set keeps earlier ones", pin_out, 64'h0000_0000_0000_00FF);
        bus_write(addr_of(K_SET, 1), 32'h8000_0001);
        chk("R4 set word1", pin_out, 64'h8000_0001_0000_00FF);
        bus_write(addr_of(K_SET, 0), 32'h0);
        chk("R4 zero set no effect", pin_out, 64'h8000_0001_0000_00FF);
        bus_write(addr_of(K_CLR, 0), 32'h0000_0030);
        chk("R5 clear word0", pin_out, 64'h8000_0001_0000_00CF);
        bus_write(addr_of(K_CLR, 1), 32'h0);
        chk("R5 zero clear no effect", pin_out, 64'h8000_0001_0000_00CF);
        bus_read(addr_of(K_SET, 0), 32'h0, "R6 set reads zero");
        bus_read(addr_of(K_CLR, 1), 32'h0, "R6 clear reads zero");

        // R2: synchronised level, two edges of latency, read-only
        pins = 64'h1234_5678_9ABC_DEF0;
        step(2);
        bus_read(addr_of(K_LEVEL, 0), 32'h9ABC_DEF0, "R2 level word0");
        bus_read(addr_of(K_LEVEL, 1), 32'h1234_5678, "R2 level word1");
        bus_write(addr_of(K_LEVEL, 0), 32'hFFFF_FFFF);
        bus_read(addr_of(K_LEVEL, 0), 32'h9ABC_DEF0, "R2 level write ignored");
        pins = '0;
        step(4);
        bus_read(addr_of(K_STAT, 0), 32'h0, "R7 no flag while disabled");

        // R7/R10/R1: rising edge on pin 33 (word1 bit1), exact latency
        bus_write(addr_of(K_RISE, 1), 32'h0000_0002);
        pins[33] = 1'b1;
        step(3);
        chk("R10 irq still low as flag sets", 64'(irq), 64'd0);
        step(1);
        chk("R10 irq one edge after flag", 64'(irq), 64'd1);
        bus_read(addr_of(K_STAT, 0), 32'h0, "R1 status word0 zero");
        bus_read(addr_of(K_STAT, 1), 32'h0000_0002, "R7 rise flag pin33");

        // R9: write-one clear, irq drops
        bus_write(addr_of(K_STAT, 1), 32'h0000_0002);
        bus_read(addr_of(K_STAT, 1), 32'h0, "R9 clear pin33");
        chk("R10 irq low after clear", 64'(irq), 64'd0);

        // R8: falling edge with only rise enabled sets nothing
        pins[33] = 1'b0;
        step(4);
        bus_read(addr_of(K_STAT, 1), 32'h0, "R8 fall ignored with rise only");

        // R8: falling-only on pin 5
        bus_write(addr_of(K_FALL, 0), 32'h0000_0020);
        pins[5] = 1'b1;
        step(4);
        bus_read(addr_of(K_STAT, 0), 32'h0, "R8 rise ignored with fall only");
        pins[5] = 1'b0;
        step(4);
        bus_read(addr_of(K_STAT, 0), 32'h0000_0020, "R8 fall flag pin5");
        bus_write(addr_of(K_STAT, 0), 32'h0000_0020);

        // R8: both enables on pin 0
        bus_write(addr_of(K_RISE, 0), 32'h0000_0001);
        bus_write(addr_of(K_FALL, 0), 32'h0000_0021);
        bus_read(addr_of(K_FALL, 0), 32'h0000_0021, "R8 fall enable readback");
        pins[0] = 1'b1;
        step(4);
        bus_read(addr_of(K_STAT, 0), 32'h0000_0001, "R8 both: rise flags pin0");

        // R9: clear captured at the same edge as a new falling edge
        pins[0] = 1'b0;
        step(2);
        bus_write(addr_of(K_STAT, 0), 32'h0000_0001);
        bus_read(addr_of(K_STAT, 0), 32'h0000_0001, "R9 edge beats same-cycle clear");
        bus_write(addr_of(K_STAT, 0), 32'h0000_0001);
        bus_read(addr_of(K_STAT, 0), 32'h0, "R9 later clear succeeds");

        // R11: beyond the map
        bus_read(ADDR_W'(7 * NREG * 4), 32'h0, "R11 oob read zero");
        bus_write(ADDR_W'(7 * NREG * 4), 32'hFFFF_FFFF);
        bus_write(ADDR_W'(7 * NREG * 4 + 4), 32'hFFFF_FFFF);
        bus_read(addr_of(K_DIR, 0), 32'h0, "R11 dir word0 unchanged");
        bus_read(addr_of(K_DIR, 1), 32'hA5A5_0F0F, "R11 dir word1 unchanged");
        chk("R11 pin_out unchanged", pin_out, 64'h8000_0001_0000_00CF);

        step(2);
        finished = 1'b1;
        if (exp_val.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard: actual=%0d left expected=0", exp_val.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule